// File: doc/BRIEF.md
# Weighted Credit Bus Arbiter

This block decides, in the same cycle as the requests arrive, which of five bus requesters owns the bus. Requesters 0 and 1 have fixed rank: requester 0 beats everyone and requester 1 beats everyone except requester 0. Requesters 2, 3 and 4 are the weighted clients. Each weighted client holds a credit counter that is loaded from a programmable 4-bit weight. Among weighted clients that are requesting and still have credit, the bus goes to the one with the most credit. Each such grant costs the client one credit.

When every requesting weighted client has run out of credit, the bus goes to the one that has waited longest. A grant of this kind is an exhausted grant. A small state machine counts exhausted grants. It has three states: `TALLY_FRESH` (no exhausted grant since the last reload), `TALLY_ONE` and `TALLY_TWO`.

- The transition *drain reload* takes any state to `TALLY_FRESH` when the three credits are all zero after the edge's update.
- The transition *exhausted advance* moves `TALLY_FRESH` to `TALLY_ONE`, and `TALLY_ONE` to `TALLY_TWO`, on an exhausted grant.
- The transition *forced reload* takes `TALLY_TWO` to `TALLY_FRESH` on the third exhausted grant. It refreshes all credits even though some were not spent.

When nobody requests, the bus can be parked on a selected requester. Weights are written through a single strobe. They reach the credit counters only at the next reload.

Top module: `wcb_arbiter`

## Requirements
- R1: While `rst_n` is low, `gnt_o` is all zero. After reset the weights and the credits of clients 2, 3 and 4 are 3, 2 and 1 (the default of `RST_WEIGHT`), and the tally state is `TALLY_FRESH`.
- R2: Whenever `req_i[0]` is high, `gnt_o` equals 5'b00001.
- R3: Whenever `req_i[1]` is high and `req_i[0]` is low, `gnt_o` equals 5'b00010.
- R4: With no fixed request, the grant goes to the weighted requester with the largest non-zero credit. On equal credit, client 2 is preferred over 3, and 3 over 4.
- R5: At each clock edge, a weighted client that is granted while holding non-zero credit loses one credit. When all three credits are zero after that update, all three are reloaded from the weight register and the tally returns to `TALLY_FRESH`.
- R6: If every requesting weighted client has zero credit, the grant goes to the one pending longest. Waiting is counted in consecutive cycles requesting without a grant, saturating at 2^AGE_W-1 and cleared when the client is granted or drops its request. On equal waiting time, client 2 is preferred over 3, and 3 over 4.
- R7: The third exhausted grant since the last reload reloads all three credits from the weight register at that edge, and the tally returns to `TALLY_FRESH`.
- R8: A high `cfg_we_i` at a clock edge stores `cfg_weight_i`. Bits [3:0] hold the weight of client 2, bits [7:4] client 3, bits [11:8] client 4. Stored weights reach the credits only at the next reload. A reload on the same edge as a write uses the weights held before the write.
- R9: With `req_i` all zero, `park_en_i` high and `park_sel_i` below 5, `gnt_o` has only bit `park_sel_i` set. With `park_sel_i` of 5 to 7, or with `park_en_i` low, `gnt_o` is zero. A parked grant leaves credits, waiting times and tally unchanged.
- R10: When all weights are zero and a reload has happened, the weighted clients are served purely oldest-request-first.
- R11: `gnt_o` never has more than one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 5 | Request lines; bit 0 and bit 1 fixed rank, bits 2..4 weighted |
| cfg_we_i | input | 1 | Weight write strobe |
| cfg_weight_i | input | 12 | Three 4-bit weights for clients 2, 3, 4 (low nibble first) |
| park_en_i | input | 1 | Allow parking the bus when idle |
| park_sel_i | input | 3 | Requester that receives the parked grant |
| gnt_o | output | 5 | One-hot grant, valid in the cycle of the request |

## Verification
A forced reload on the third exhausted grant can fall on the same edge as a drain reload, and either can coincide with a weight write. The bench provokes this by writing new weights at the start of each configuration of a sweep over weight values, while pseudo-random requests keep draining credit. A reference model kept in the bench predicts every grant. It reloads with the pre-write weights, so any wrong choice of reload source shows up as a later grant that differs from the prediction. Directed sequences also count grants after a forced reload to show that credits were really refilled.

// File: rtl/wcb_pkg.sv
package wcb_pkg;
    localparam int NCLI   = 5;
    localparam int FIXED  = 2;
    localparam int NPROG  = NCLI - FIXED;
    localparam int IDX_W  = $clog2(NCLI);
    localparam int PIDX_W = $clog2(NPROG);

    typedef enum logic [1:0] {
        TALLY_FRESH = 2'd0,
        TALLY_ONE   = 2'd1,
        TALLY_TWO   = 2'd2
    } tally_e;

    typedef enum logic [2:0] {
        SRC_NONE   = 3'd0,
        SRC_TOP    = 3'd1,
        SRC_SECOND = 3'd2,
        SRC_CREDIT = 3'd3,
        SRC_AGE    = 3'd4,
        SRC_PARK   = 3'd5
    } src_e;
endpackage

// File: rtl/wcb_credit_bank.sv
module wcb_credit_bank
    import wcb_pkg::*;
#(
    parameter int               CW         = 4,
    parameter logic [NPROG*CW-1:0] RST_WEIGHT = 'h123
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [NPROG*CW-1:0] cfg_wdata,
    input  logic [NPROG-1:0]    take,
    input  logic                reload,
    output logic [NPROG*CW-1:0] cnt_flat,
    output logic [NPROG*CW-1:0] wgt_flat,
    output logic [NPROG-1:0]    cnt_zero,
    output logic                all_zero_nxt
);
    logic [NPROG-1:0] nxt_zero;

    for (genvar i = 0; i < NPROG; i++) begin : g_cli
        logic [CW-1:0] wgt_q;
        logic [CW-1:0] cnt_q;
        logic [CW-1:0] cnt_nxt;

        always_comb begin
            cnt_nxt = cnt_q;
            if (take[i] && (cnt_q != '0)) begin
                cnt_nxt = cnt_q - CW'(1);
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                wgt_q <= RST_WEIGHT[i*CW +: CW];
            end else if (cfg_we) begin
                wgt_q <= cfg_wdata[i*CW +: CW];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cnt_q <= RST_WEIGHT[i*CW +: CW];
            end else if (reload) begin
                cnt_q <= wgt_q;
            end else begin
                cnt_q <= cnt_nxt;
            end
        end

        assign cnt_flat[i*CW +: CW] = cnt_q;
        assign wgt_flat[i*CW +: CW] = wgt_q;
        assign cnt_zero[i]          = (cnt_q == '0);
        assign nxt_zero[i]          = (cnt_nxt == '0);
    end

    assign all_zero_nxt = &nxt_zero;
endmodule

// File: rtl/wcb_age_tracker.sv
module wcb_age_tracker
    import wcb_pkg::*;
#(
    parameter int AGE_W = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NPROG-1:0]       req,
    input  logic [NPROG-1:0]       granted,
    output logic [NPROG*AGE_W-1:0] age_flat
);
    localparam logic [AGE_W-1:0] AGE_MAX = '1;

    for (genvar i = 0; i < NPROG; i++) begin : g_age
        logic [AGE_W-1:0] age_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                age_q <= '0;
            end else if (req[i] && !granted[i]) begin
                if (age_q != AGE_MAX) begin
                    age_q <= age_q + AGE_W'(1);
                end
            end else begin
                age_q <= '0;
            end
        end

        assign age_flat[i*AGE_W +: AGE_W] = age_q;
    end
endmodule

// File: rtl/wcb_pick.sv
module wcb_pick
    import wcb_pkg::*;
#(
    parameter int CW    = 4,
    parameter int AGE_W = 5
) (
    input  logic [NPROG-1:0]       req,
    input  logic [NPROG*CW-1:0]    cnt_flat,
    input  logic [NPROG*AGE_W-1:0] age_flat,
    output logic                   credit_hit,
    output logic [PIDX_W-1:0]      credit_idx,
    output logic                   age_hit,
    output logic [PIDX_W-1:0]      age_idx
);
    logic [CW-1:0]    best_cnt;
    logic [AGE_W-1:0] best_age;

    always_comb begin
        credit_hit = 1'b0;
        credit_idx = '0;
        best_cnt   = '0;
        for (int i = 0; i < NPROG; i++) begin
            if (req[i] && (cnt_flat[i*CW +: CW] != '0) &&
                (!credit_hit || (cnt_flat[i*CW +: CW] > best_cnt))) begin
                credit_hit = 1'b1;
                credit_idx = PIDX_W'(i);
                best_cnt   = cnt_flat[i*CW +: CW];
            end
        end
    end

    always_comb begin
        age_hit  = 1'b0;
        age_idx  = '0;
        best_age = '0;
        for (int i = 0; i < NPROG; i++) begin
            if (req[i] && (!age_hit || (age_flat[i*AGE_W +: AGE_W] > best_age))) begin
                age_hit  = 1'b1;
                age_idx  = PIDX_W'(i);
                best_age = age_flat[i*AGE_W +: AGE_W];
            end
        end
    end
endmodule

// File: rtl/wcb_arbiter.sv
module wcb_arbiter
    import wcb_pkg::*;
#(
    parameter int                  CW         = 4,
    parameter int                  AGE_W      = 5,
    parameter logic [NPROG*CW-1:0] RST_WEIGHT = 'h123
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NCLI-1:0]     req_i,
    input  logic                cfg_we_i,
    input  logic [NPROG*CW-1:0] cfg_weight_i,
    input  logic                park_en_i,
    input  logic [IDX_W-1:0]    park_sel_i,
    output logic [NCLI-1:0]     gnt_o
);
    logic [NPROG*CW-1:0]    cnt_flat;
    logic [NPROG*CW-1:0]    wgt_flat;
    logic [NPROG*AGE_W-1:0] age_flat;
    logic [NPROG-1:0]       req_prog;
    logic [NPROG-1:0]       prog_take;
    logic [NPROG-1:0]       cnt_zero;
    logic                   credit_hit;
    logic                   age_hit;
    logic [PIDX_W-1:0]      credit_idx;
    logic [PIDX_W-1:0]      age_idx;
    logic                   all_zero_nxt;
    logic                   zero_gnt;
    logic                   reload;
    logic                   tally_full;
    tally_e                 state_q;
    tally_e                 state_d;
    src_e                   src;

    assign req_prog = req_i[NCLI-1:FIXED];

    wcb_pick #(.CW(CW), .AGE_W(AGE_W)) u_pick (
        .req        (req_prog),
        .cnt_flat   (cnt_flat),
        .age_flat   (age_flat),
        .credit_hit (credit_hit),
        .credit_idx (credit_idx),
        .age_hit    (age_hit),
        .age_idx    (age_idx)
    );

    // Output process: grant decision in priority order
    always_comb begin
        gnt_o = '0;
        src   = SRC_NONE;
        if (!rst_n) begin
            src = SRC_NONE;
        end else if (req_i[0]) begin
            gnt_o[0] = 1'b1;
            src      = SRC_TOP;
        end else if (req_i[1]) begin
            gnt_o[1] = 1'b1;
            src      = SRC_SECOND;
        end else if (credit_hit) begin
            for (int i = 0; i < NPROG; i++) begin
                if (credit_idx == PIDX_W'(i)) gnt_o[FIXED+i] = 1'b1;
            end
            src = SRC_CREDIT;
        end else if (age_hit) begin
            for (int i = 0; i < NPROG; i++) begin
                if (age_idx == PIDX_W'(i)) gnt_o[FIXED+i] = 1'b1;
            end
            src = SRC_AGE;
        end else if (park_en_i) begin
            for (int k = 0; k < NCLI; k++) begin
                if (park_sel_i == IDX_W'(k)) gnt_o[k] = 1'b1;
            end
            src = SRC_PARK;
        end
    end

    assign prog_take  = gnt_o[NCLI-1:FIXED] & req_prog;
    assign zero_gnt   = (src == SRC_AGE) && |(prog_take & cnt_zero);
    assign tally_full = (state_q == TALLY_TWO);
    assign reload     = all_zero_nxt || (zero_gnt && tally_full);

    // Next-state process: tally of exhausted grants
    always_comb begin
        state_d = state_q;
        if (reload) begin
            state_d = TALLY_FRESH;
        end else if (zero_gnt) begin
            unique case (state_q)
                TALLY_FRESH: state_d = TALLY_ONE;
                TALLY_ONE:   state_d = TALLY_TWO;
                TALLY_TWO:   state_d = TALLY_FRESH;
                default:     state_d = TALLY_FRESH;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TALLY_FRESH;
        end else begin
            state_q <= state_d;
        end
    end

    wcb_credit_bank #(.CW(CW), .RST_WEIGHT(RST_WEIGHT)) u_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we       (cfg_we_i),
        .cfg_wdata    (cfg_weight_i),
        .take         (prog_take),
        .reload       (reload),
        .cnt_flat     (cnt_flat),
        .wgt_flat     (wgt_flat),
        .cnt_zero     (cnt_zero),
        .all_zero_nxt (all_zero_nxt)
    );

    wcb_age_tracker #(.AGE_W(AGE_W)) u_age (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req_prog),
        .granted  (prog_take),
        .age_flat (age_flat)
    );
endmodule

// File: rtl/wcb_arbiter_chk.sv
module wcb_arbiter_chk
    import wcb_pkg::*;
#(
    parameter int CW = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NCLI-1:0]     req_i,
    input logic [NCLI-1:0]     gnt_o,
    input logic                park_en_i,
    input logic [IDX_W-1:0]    park_sel_i,
    input logic [NPROG*CW-1:0] cnt_flat,
    input logic [NPROG*CW-1:0] wgt_flat,
    input logic                zero_gnt,
    input logic                tally_full
);
    logic credit_req;

    always_comb begin
        credit_req = 1'b0;
        for (int i = 0; i < NPROG; i++) begin
            if (req_i[FIXED+i] && (cnt_flat[i*CW +: CW] != '0)) credit_req = 1'b1;
        end
    end

    AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_o)); // R11

    AST_TOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        req_i[0] |-> (gnt_o == NCLI'(1))); // R2

    AST_SECOND_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_i[0] && req_i[1]) |-> (gnt_o == NCLI'(2))); // R3

    AST_GNT_TO_REQUESTER: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i != '0) |-> ((gnt_o & ~req_i) == '0)); // R4

    AST_EXHAUSTED_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        zero_gnt |-> !credit_req); // R6

    AST_FORCED_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_gnt && tally_full) |=> (cnt_flat == $past(wgt_flat))); // R7

    AST_PARK_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (park_en_i && (req_i == '0) && (park_sel_i < IDX_W'(NCLI)))
        |-> (gnt_o == (NCLI'(1) << park_sel_i))); // R9

    AST_IDLE_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (!park_en_i && (req_i == '0)) |-> (gnt_o == '0)); // R9

    AST_IDLE_KEEPS_CREDIT: assert property (@(posedge clk) disable iff (!rst_n)
        ((req_i == '0) && (cnt_flat != '0)) |=> $stable(cnt_flat)); // R9

    for (genvar i = 0; i < NPROG; i++) begin : g_dec
        AST_CREDIT_DEC: assert property (@(posedge clk) disable iff (!rst_n)
            (gnt_o[FIXED+i] && req_i[FIXED+i] && (cnt_flat[i*CW +: CW] > CW'(1)))
            |=> (cnt_flat[i*CW +: CW] == $past(cnt_flat[i*CW +: CW]) - CW'(1))); // R5
    end
endmodule

bind wcb_arbiter wcb_arbiter_chk #(.CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (req_i),
    .gnt_o      (gnt_o),
    .park_en_i  (park_en_i),
    .park_sel_i (park_sel_i),
    .cnt_flat   (cnt_flat),
    .wgt_flat   (wgt_flat),
    .zero_gnt   (zero_gnt),
    .tally_full (tally_full)
);

// File: tb/tb_wcb_arbiter.sv
module tb_wcb_arbiter;
    localparam int CLK_P   = 10;
    localparam int AGE_MAX = 31;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  req = '0;
    logic        cfg_we = 1'b0;
    logic [11:0] cfg_d = '0;
    logic        park_en = 1'b0;
    logic [2:0]  park_sel = '0;
    logic [4:0]  gnt;
    logic [4:0]  seen;
    logic [15:0] lf = 16'hACE1;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    int mcnt[3];
    int mwgt[3];
    int mage[3];
    int mtally;

    always #(CLK_P/2) clk = ~clk;

    wcb_arbiter dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_i        (req),
        .cfg_we_i     (cfg_we),
        .cfg_weight_i (cfg_d),
        .park_en_i    (park_en),
        .park_sel_i   (park_sel),
        .gnt_o        (gnt)
    );

    task automatic chk(input bit ok, input string r, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", r, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    function automatic logic [4:0] model_gnt(output string why);
        int best;
        bit allw;
        model_gnt = '0;
        why = "R9";
        best = -1;
        if (req[0]) begin
            model_gnt = 5'b00001; why = "R2";
        end else if (req[1]) begin
            model_gnt = 5'b00010; why = "R3";
        end else begin
            for (int i = 0; i < 3; i++)
                if (req[2+i] && mcnt[i] != 0 && (best < 0 || mcnt[i] > mcnt[best])) best = i;
            if (best >= 0) begin
                model_gnt[2+best] = 1'b1; why = "R4";
            end else begin
                for (int i = 0; i < 3; i++)
                    if (req[2+i] && (best < 0 || mage[i] > mage[best])) best = i;
                if (best >= 0) begin
                    allw = (mwgt[0] == 0) && (mwgt[1] == 0) && (mwgt[2] == 0);
                    model_gnt[2+best] = 1'b1;
                    why = allw ? "R10" : "R6";
                end else if (park_en && park_sel < 3'd5) begin
                    model_gnt[park_sel] = 1'b1;
                end
            end
        end
    endfunction

    task automatic step();
        string why;
        logic [4:0] e;
        int gi;
        int nc[3];
        bit zg;
        bit allz;
        #(CLK_P/4);
        e = model_gnt(why);
        seen = gnt;
        chk(gnt === e, why, int'(gnt), int'(e));
        chk($onehot0(gnt), "R11", int'(gnt), int'(e));
        gi = -1;
        for (int i = 0; i < 3; i++) if (e[2+i] && req[2+i]) gi = i;
        zg = 0;
        for (int i = 0; i < 3; i++) nc[i] = mcnt[i];
        if (gi >= 0) begin
            if (mcnt[gi] == 0) zg = 1;
            else nc[gi] = nc[gi] - 1;
        end
        allz = (nc[0] == 0) && (nc[1] == 0) && (nc[2] == 0);
        @(posedge clk);
        if (allz || (zg && mtally == 2)) begin
            for (int i = 0; i < 3; i++) mcnt[i] = mwgt[i];
            mtally = 0;
        end else begin
            for (int i = 0; i < 3; i++) mcnt[i] = nc[i];
            mtally = mtally + int'(zg);
        end
        for (int i = 0; i < 3; i++)
            mage[i] = (req[2+i] && !e[2+i]) ? ((mage[i] < AGE_MAX) ? mage[i] + 1 : AGE_MAX) : 0;
        if (cfg_we)
            for (int i = 0; i < 3; i++) mwgt[i] = int'(cfg_d[i*4 +: 4]);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        req = 5'b11111;
        cfg_we = 1'b0;
        park_en = 1'b1;
        repeat (2) @(negedge clk);
        #(CLK_P/4);
        chk(gnt === 5'b0, "R1", int'(gnt), 0);
        @(negedge clk);
        rst_n = 1'b1;
        req = '0;
        park_en = 1'b0;
        mwgt[0] = 3; mwgt[1] = 2; mwgt[2] = 1;
        for (int i = 0; i < 3; i++) begin mcnt[i] = mwgt[i]; mage[i] = 0; end
        mtally = 0;
    endtask

    function automatic logic [3:0] wsel(input int k);
        case (k)
            0: wsel = 4'd0;
            1: wsel = 4'd1;
            2: wsel = 4'd3;
            default: wsel = 4'd15;
        endcase
    endfunction

    initial begin
        #(CLK_P * 150000);
        chk(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        int cnt4;
        logic [4:0] exp_seq[6];
        @(negedge clk);

        // R1 + R5: reset state, drain order and reload with weights 3,2,1
        do_reset();
        exp_seq[0] = 5'b00100; exp_seq[1] = 5'b00100; exp_seq[2] = 5'b01000;
        exp_seq[3] = 5'b00100; exp_seq[4] = 5'b01000; exp_seq[5] = 5'b10000;
        req = 5'b11100;
        cfg_we = 1'b1; cfg_d = 12'h410;
        for (int s = 0; s < 6; s++) begin
            step();
            cfg_we = 1'b0;
            chk(seen === exp_seq[s], "R5", int'(seen), int'(exp_seq[s]));
        end
        // R7: spend 2 of 4 credits on client 4, three exhausted grants, then count
        req = 5'b10100; step(); step();
        req = 5'b00100; step(); step(); step();
        req = 5'b10100;
        cnt4 = 0;
        for (int s = 0; s < 5; s++) begin
            step();
            if (seen === 5'b10000) cnt4++;
        end
        chk(cnt4 == 4, "R7", cnt4, 4);

        // R8: written weight waits for the next reload
        do_reset();
        req = 5'b00000; cfg_we = 1'b1; cfg_d = 12'hF23;
        step();
        cfg_we = 1'b0;
        req = 5'b11000; step();
        chk(seen === 5'b01000, "R8", int'(seen), 8);
        req = 5'b11100;
        for (int s = 0; s < 5; s++) step();
        req = 5'b10100; step();
        chk(seen === 5'b10000, "R8", int'(seen), 16);

        // R10: all-zero weights give oldest-first order
        do_reset();
        req = 5'b11100; cfg_we = 1'b1; cfg_d = 12'h000;
        for (int s = 0; s < 6; s++) begin step(); cfg_we = 1'b0; end
        req = 5'b10001; step();
        req = 5'b10101; step();
        req = 5'b10100; step();
        chk(seen === 5'b10000, "R10", int'(seen), 16);
        step();
        chk(seen === 5'b00100, "R10", int'(seen), 4);

        // R9: parking
        req = '0; park_en = 1'b1; park_sel = 3'd3; step();
        chk(seen === 5'b01000, "R9", int'(seen), 8);
        park_sel = 3'd6; step();
        chk(seen === 5'b00000, "R9", int'(seen), 0);
        park_en = 1'b0; park_sel = 3'd1; step();
        chk(seen === 5'b00000, "R9", int'(seen), 0);

        // Sweep over weight sets, park settings and pseudo-random requests
        do_reset();
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                for (int c = 0; c < 4; c++) begin
                    cfg_we = 1'b1;
                    cfg_d = {wsel(c), wsel(b), wsel(a)};
                    park_en = 1'(a ^ c);
                    park_sel = 3'((a + b * 3 + c) % 8);
                    for (int s = 0; s < 40; s++) begin
                        req[0] = lf[0] & lf[1] & lf[2];
                        req[1] = lf[3] & lf[4] & lf[5];
                        req[4:2] = lf[8:6] & {3{lf[9] | lf[10]}};
                        step();
                        cfg_we = 1'b0;
                        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                    end
                end
            end
        end
        finish_run();
    end
endmodule